// File: doc/BRIEF.md
# Load/Store Alignment Exception Checker

This block sits in the load/store issue stage and decides whether an access must raise an alignment exception. The decision does not depend on the address alone. It takes into account the class of operation, the attributes of the target memory, the data-cache mode and the little-endian mode. An ordinary integer access that is misaligned never faults here, whatever the endian mode, because the memory pipeline splits such accesses itself.

For each access, the issue logic presents the operation class, the effective address, the length in bytes and the attributes. The checker evaluates seven fault conditions in parallel. It reports a single flag and a 3-bit cause code that names the lowest-numbered active condition. The decision is combinational, and a register stage captures it so that the result lines up with the next pipeline stage. The result is therefore visible one clock after the inputs are presented.

A word is 4 bytes, so an address is word-aligned when its two low bits are zero. The segment is taken from the top four address bits. The access crosses a segment when the first and last bytes carry different segment bits. The last byte is the address plus the length minus one, and a zero length counts as the single byte at the address.

Top module: `lsu_align_check`

## Requirements
- R1: A floating-point access (op_class 1) whose target segment is direct-store (seg_direct=1) faults with cause 1.
- R2: A floating-point access (op_class 1) whose address has ea[1:0] not equal to 0 faults with cause 2. An aligned floating-point access to a normal segment does not fault.
- R3: A load/store multiple (op_class 2) or a reservation load / conditional store (op_class 4) with ea[1:0] not equal to 0 faults with cause 3. Aligned ones do not fault.
- R4: An integer single (op_class 0), multiple (op_class 2) or string (op_class 3) access whose first and last bytes differ in ea[31:28], while ds_change=1, faults with cause 4. The same crossing with ds_change=0 does not fault.
- R5: A cache-block-zero operation (op_class 5) faults with cause 5 when pg_wt=1, when pg_ci=1, or when dc_mode is 0 (no data cache) or 1 (write-through). With dc_mode 2 (copy-back) and neither attribute set, it does not fault.
- R6: An external control in/out access (op_class 6) with ea[1:0] not equal to 0 faults with cause 6. An aligned one does not fault.
- R7: A multiple (op_class 2) or string (op_class 3) access faults with cause 7 whenever le_mode=1, even when it is aligned.
- R8: An integer single access (op_class 0) that is misaligned but does not cross a direct-store change does not fault, for both le_mode=0 and le_mode=1. op_class 7 never faults.
- R9: When several conditions hold, align_cause is the lowest-numbered one. align_exc is 1 exactly when align_cause is non-zero.
- R10: The outputs show the decision for the inputs present at the previous rising clock edge. While rst_n is low at an edge, both outputs go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_class | input | 3 | Operation class: 0 int single, 1 FP, 2 multiple, 3 string, 4 reservation, 5 block zero, 6 external control, 7 none |
| ea | input | 32 | Effective address of the first byte |
| acc_len | input | 8 | Access length in bytes (0 treated as 1) |
| seg_direct | input | 1 | Target segment is direct-store |
| ds_change | input | 1 | The following segment differs in its direct-store flag |
| pg_wt | input | 1 | Page is write-through |
| pg_ci | input | 1 | Page is cache-inhibited |
| dc_mode | input | 2 | Data-cache mode: 0 absent, 1 write-through, 2 copy-back, 3 treated as copy-back |
| le_mode | input | 1 | Little-endian mode |
| align_exc | output | 1 | Alignment exception flag, registered |
| align_cause | output | 3 | Cause code 1..7, 0 when no fault, registered |

## Verification
The only state in this block is the output register. Apart from that, a wrong condition term or a wrong priority order shows up directly as a wrong flag or cause. The error appears exactly one clock after the offending input pattern. If the flag and the cause disagree, the OR path and the encoder path have diverged, which is visible on the same cycle. If the register fails to clear, a stale fault stays on the ports during reset. The vectors therefore pair each condition with its near-miss (aligned, no direct-store change, copy-back cache, ordinary little-endian access) and stack conditions to expose the encoder order.

// File: rtl/lsu_align_pkg.sv
// Package: shared encodings for the load/store alignment checker.
// Assumes op_class and dc_mode arrive as the plain codes listed below.
package lsu_align_pkg;

    localparam int OPC_W   = 3;
    localparam int DCM_W   = 2;
    localparam int NUM_CND = 7;
    localparam int CAUSE_W = $clog2(NUM_CND + 1);

    typedef enum logic [OPC_W-1:0] {
        OPC_INT    = 3'd0,
        OPC_FP     = 3'd1,
        OPC_MULTI  = 3'd2,
        OPC_STRING = 3'd3,
        OPC_RESV   = 3'd4,
        OPC_BLKZ   = 3'd5,
        OPC_EXTCTL = 3'd6,
        OPC_NONE   = 3'd7
    } op_class_e;

    typedef enum logic [DCM_W-1:0] {
        DC_ABSENT = 2'd0,
        DC_WTHRU  = 2'd1,
        DC_CBACK  = 2'd2,
        DC_RSVD   = 2'd3
    } dc_mode_e;

    // Bit index of each condition; cause code = index + 1 (lower wins)
    localparam int CND_FP_DIRECT  = 0;
    localparam int CND_FP_MISAL   = 1;
    localparam int CND_WORD_MISAL = 2;
    localparam int CND_SEG_CROSS  = 3;
    localparam int CND_BLKZ_ATTR  = 4;
    localparam int CND_EXT_MISAL  = 5;
    localparam int CND_LE_MULTI   = 6;

endpackage

// File: rtl/lsu_align_addr.sv
// Module: lsu_align_addr
// Derives address properties of one access: whether the first byte is
// aligned to ALIGN_BYTES, and whether the first and last bytes sit in
// different segments (top SEG_W address bits). Assumes ALIGN_BYTES is a
// power of two and the access length is far smaller than a segment.
module lsu_align_addr #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 8,
    parameter int SEG_W       = 4,
    parameter int ALIGN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic [LEN_W-1:0]  acc_len,
    output logic              misaligned,
    output logic              seg_cross
);
    localparam int LOW_W = $clog2(ALIGN_BYTES);

    logic [ADDR_W-1:0] last_byte;
    logic              len_nonzero;

    // Misalignment: any low address bit below the alignment unit is set
    always_comb begin
        misaligned = |ea[LOW_W-1:0];
    end

    // Last byte address; a zero length counts as the single first byte
    always_comb begin
        len_nonzero = |acc_len;
        last_byte   = ea + ADDR_W'(acc_len) - ADDR_W'(len_nonzero);
    end

    // Segment crossing: segment bits of first and last byte differ
    always_comb begin
        seg_cross = ea[ADDR_W-1 -: SEG_W] != last_byte[ADDR_W-1 -: SEG_W];
    end

endmodule

// File: rtl/lsu_align_conds.sv
// Module: lsu_align_conds
// Evaluates every alignment-fault condition in parallel and returns them
// as a vector indexed by the lsu_align_pkg condition indices. Assumes the
// address properties come from lsu_align_addr for the same access.
module lsu_align_conds
    import lsu_align_pkg::*;
(
    input  logic [OPC_W-1:0]   op_class,
    input  logic               misaligned,
    input  logic               seg_cross,
    input  logic               seg_direct,
    input  logic               ds_change,
    input  logic               pg_wt,
    input  logic               pg_ci,
    input  logic [DCM_W-1:0]   dc_mode,
    input  logic               le_mode,
    output logic [NUM_CND-1:0] cond
);
    op_class_e op;
    dc_mode_e  dcm;
    logic      is_fp, is_multi, is_string, is_resv, is_int, is_blkz, is_ext;
    logic      cache_unfit;

    // Decode the operation class into one-hot style flags
    always_comb begin
        op        = op_class_e'(op_class);
        is_int    = (op == OPC_INT);
        is_fp     = (op == OPC_FP);
        is_multi  = (op == OPC_MULTI);
        is_string = (op == OPC_STRING);
        is_resv   = (op == OPC_RESV);
        is_blkz   = (op == OPC_BLKZ);
        is_ext    = (op == OPC_EXTCTL);
    end

    // Block zero cannot proceed without a copy-back data cache
    always_comb begin
        dcm         = dc_mode_e'(dc_mode);
        cache_unfit = pg_wt || pg_ci || (dcm == DC_ABSENT) || (dcm == DC_WTHRU);
    end

    // Individual fault terms, one per condition index
    always_comb begin
        cond                 = '0;
        cond[CND_FP_DIRECT]  = is_fp && seg_direct;
        cond[CND_FP_MISAL]   = is_fp && misaligned;
        cond[CND_WORD_MISAL] = (is_multi || is_resv) && misaligned;
        cond[CND_SEG_CROSS]  = (is_int || is_multi || is_string) && seg_cross && ds_change;
        cond[CND_BLKZ_ATTR]  = is_blkz && cache_unfit;
        cond[CND_EXT_MISAL]  = is_ext && misaligned;
        cond[CND_LE_MULTI]   = (is_multi || is_string) && le_mode;
    end

endmodule

// File: rtl/lsu_align_prio.sv
// Module: lsu_align_prio
// Turns a condition vector into a cause code naming the lowest set
// condition (index + 1), or zero when none is set, plus an OR flag.
// Assumes CAUSE_W can hold N.
module lsu_align_prio #(
    parameter int N       = 7,
    parameter int CAUSE_W = 3
) (
    input  logic [N-1:0]       cond,
    output logic               any,
    output logic [CAUSE_W-1:0] cause
);
    // Flag is the OR of all conditions
    always_comb begin
        any = |cond;
    end

    // Scan downward so the lowest set index is written last and wins
    always_comb begin
        cause = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cond[i]) begin
                cause = CAUSE_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/lsu_align_check.sv
// Module: lsu_align_check (top)
// Load/store alignment exception checker. Combines address analysis,
// condition evaluation and priority encoding, then registers the flag and
// cause for the next pipeline stage. Assumes inputs are stable around the
// rising clock edge; reset is synchronous and active low.
module lsu_align_check
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 8,
    parameter int SEG_W       = 4,
    parameter int ALIGN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPC_W-1:0]   op_class,
    input  logic [ADDR_W-1:0]  ea,
    input  logic [LEN_W-1:0]   acc_len,
    input  logic               seg_direct,
    input  logic               ds_change,
    input  logic               pg_wt,
    input  logic               pg_ci,
    input  logic [DCM_W-1:0]   dc_mode,
    input  logic               le_mode,
    output logic               align_exc,
    output logic [CAUSE_W-1:0] align_cause
);
    logic               misaligned;
    logic               seg_cross;
    logic [NUM_CND-1:0] cond;
    logic               exc_d;
    logic [CAUSE_W-1:0] cause_d;

    lsu_align_addr #(
        .ADDR_W      (ADDR_W),
        .LEN_W       (LEN_W),
        .SEG_W       (SEG_W),
        .ALIGN_BYTES (ALIGN_BYTES)
    ) u_addr (
        .ea         (ea),
        .acc_len    (acc_len),
        .misaligned (misaligned),
        .seg_cross  (seg_cross)
    );

    lsu_align_conds u_conds (
        .op_class   (op_class),
        .misaligned (misaligned),
        .seg_cross  (seg_cross),
        .seg_direct (seg_direct),
        .ds_change  (ds_change),
        .pg_wt      (pg_wt),
        .pg_ci      (pg_ci),
        .dc_mode    (dc_mode),
        .le_mode    (le_mode),
        .cond       (cond)
    );

    lsu_align_prio #(
        .N       (NUM_CND),
        .CAUSE_W (CAUSE_W)
    ) u_prio (
        .cond  (cond),
        .any   (exc_d),
        .cause (cause_d)
    );

    // Output stage register, cleared by synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            align_exc   <= 1'b0;
            align_cause <= '0;
        end else begin
            align_exc   <= exc_d;
            align_cause <= cause_d;
        end
    end

endmodule

// File: rtl/lsu_align_check_sva.sv
// Module: lsu_align_check_sva
// Assertion checker bound to lsu_align_check. Relates the registered
// outputs to the inputs of the previous cycle for selected requirements.
module lsu_align_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_class,
    input logic [31:0] ea,
    input logic        seg_direct,
    input logic        ds_change,
    input logic [1:0]  dc_mode,
    input logic        align_exc,
    input logic [2:0]  align_cause
);
    // R1: floating-point access to a direct-store segment reports cause 1
    p_fp_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_class) == 3'd1 && $past(seg_direct))
        |-> (align_exc && align_cause == 3'd1));

    // R5: block zero without a data cache always faults with cause 5
    p_blkz_nocache_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_class) == 3'd5 && $past(dc_mode) == 2'd0)
        |-> (align_exc && align_cause == 3'd5));

    // R6: aligned external control access never faults
    p_ext_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_class) == 3'd6 && $past(ea[1:0]) == 2'd0)
        |-> !align_exc);

    // R8: integer single access without a direct-store change never faults
    p_int_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_class) == 3'd0 && !$past(ds_change))
        |-> !align_exc);

    // R9: flag and cause agree every cycle
    p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        align_exc == (align_cause != 3'd0));

    // R10: an edge with reset low leaves both outputs cleared
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!align_exc && align_cause == 3'd0));

endmodule

bind lsu_align_check lsu_align_check_sva i_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_class    (op_class),
    .ea          (ea),
    .seg_direct  (seg_direct),
    .ds_change   (ds_change),
    .dc_mode     (dc_mode),
    .align_exc   (align_exc),
    .align_cause (align_cause)
);

// File: tb/test_lsu_align_check.sv
`timescale 1ns/1ps
// Scoreboard bench: drive() applies a vector and queues the expected
// result; the monitor pops one item per cycle and compares.
module test_lsu_align_check;

    typedef struct {
        logic       exc;
        logic [2:0] cause;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_class = 3'd7;
    logic [31:0] ea = '0;
    logic [7:0]  acc_len = 8'd4;
    logic        seg_direct = 1'b0;
    logic        ds_change = 1'b0;
    logic        pg_wt = 1'b0;
    logic        pg_ci = 1'b0;
    logic [1:0]  dc_mode = 2'd2;
    logic        le_mode = 1'b0;
    logic        align_exc;
    logic [2:0]  align_cause;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    exp_t item;

    always #2.5 clk = ~clk;

    lsu_align_check i_lsu_align_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_class    (op_class),
        .ea          (ea),
        .acc_len     (acc_len),
        .seg_direct  (seg_direct),
        .ds_change   (ds_change),
        .pg_wt       (pg_wt),
        .pg_ci       (pg_ci),
        .dc_mode     (dc_mode),
        .le_mode     (le_mode),
        .align_exc   (align_exc),
        .align_cause (align_cause)
    );

    task automatic check(input string tag, input logic e_exc, input logic [2:0] e_cause);
        checks++;
        if (align_exc !== e_exc || align_cause !== e_cause) begin
            errors++;
            $display("FAIL %s: exc=%0b cause=%0d expected exc=%0b cause=%0d",
                     tag, align_exc, align_cause, e_exc, e_cause);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [7:0] n,
                         input logic ds, input logic chg, input logic wt, input logic ci,
                         input logic [1:0] dc, input logic le,
                         input logic e_exc, input logic [2:0] e_cause, input string tag);
        @(negedge clk);
        op_class = op; ea = a; acc_len = n; seg_direct = ds; ds_change = chg;
        pg_wt = wt; pg_ci = ci; dc_mode = dc; le_mode = le;
        sb_q.push_back('{e_exc, e_cause, tag});
    endtask

    // Monitor: result of the vector set at the last falling edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item = sb_q.pop_front();
            check(item.tag, item.exc, item.cause);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: outputs held at zero during reset even with a faulting input
        op_class = 3'd1; seg_direct = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R10 reset", 1'b0, 3'd0);
        @(negedge clk); rst_n = 1'b1;

        //      op    ea             len  ds chg wt ci dc le   exc cause
        drive(3'd1, 32'h0000_1000, 8'd8, 1, 0, 0, 0, 2, 0, 1, 3'd1, "R1 fp direct");
        drive(3'd1, 32'h0000_1002, 8'd4, 0, 0, 0, 0, 2, 0, 1, 3'd2, "R2 fp misaligned");
        drive(3'd1, 32'h0000_1004, 8'd8, 0, 0, 0, 0, 2, 0, 0, 3'd0, "R2 fp aligned");
        drive(3'd2, 32'h0000_2001, 8'd16,0, 0, 0, 0, 2, 0, 1, 3'd3, "R3 multi misaligned");
        drive(3'd4, 32'h0000_2006, 8'd4, 0, 0, 0, 0, 2, 0, 1, 3'd3, "R3 resv misaligned");
        drive(3'd4, 32'h0000_2008, 8'd4, 0, 0, 0, 0, 2, 0, 0, 3'd0, "R3 resv aligned");
        drive(3'd0, 32'h1FFF_FFFE, 8'd4, 0, 1, 0, 0, 2, 0, 1, 3'd4, "R4 int cross change");
        drive(3'd0, 32'h1FFF_FFFE, 8'd4, 0, 0, 0, 0, 2, 0, 0, 3'd0, "R4 int cross no change");
        drive(3'd3, 32'h1FFF_FFF0, 8'd32,0, 1, 0, 0, 2, 0, 1, 3'd4, "R4 string cross change");
        drive(3'd0, 32'h1FFF_FFFC, 8'd4, 0, 1, 0, 0, 2, 0, 0, 3'd0, "R4 last byte in segment");
        drive(3'd5, 32'h0000_3000, 8'd32,0, 0, 1, 0, 2, 0, 1, 3'd5, "R5 blkz write-through page");
        drive(3'd5, 32'h0000_3000, 8'd32,0, 0, 0, 1, 2, 0, 1, 3'd5, "R5 blkz inhibited page");
        drive(3'd5, 32'h0000_3000, 8'd32,0, 0, 0, 0, 0, 0, 1, 3'd5, "R5 blkz no cache");
        drive(3'd5, 32'h0000_3000, 8'd32,0, 0, 0, 0, 1, 0, 1, 3'd5, "R5 blkz wt cache");
        drive(3'd5, 32'h0000_3000, 8'd32,0, 0, 0, 0, 2, 0, 0, 3'd0, "R5 blkz copy-back ok");
        drive(3'd6, 32'h0000_3003, 8'd4, 0, 0, 0, 0, 2, 0, 1, 3'd6, "R6 ext misaligned");
        drive(3'd6, 32'h0000_3004, 8'd4, 0, 0, 0, 0, 2, 0, 0, 3'd0, "R6 ext aligned");
        drive(3'd3, 32'h0000_4000, 8'd8, 0, 0, 0, 0, 2, 1, 1, 3'd7, "R7 string le");
        drive(3'd2, 32'h0000_4000, 8'd8, 0, 0, 0, 0, 2, 1, 1, 3'd7, "R7 multi le aligned");
        drive(3'd0, 32'h0000_4003, 8'd4, 0, 0, 0, 0, 2, 1, 0, 3'd0, "R8 int misaligned le");
        drive(3'd0, 32'h0000_4003, 8'd4, 0, 0, 0, 0, 2, 0, 0, 3'd0, "R8 int misaligned be");
        drive(3'd7, 32'h0000_4003, 8'd4, 1, 1, 1, 1, 0, 1, 0, 3'd0, "R8 op none");
        drive(3'd1, 32'h0000_5002, 8'd4, 1, 0, 0, 0, 2, 0, 1, 3'd1, "R9 fp direct over misal");
        drive(3'd2, 32'h1FFF_FFFD, 8'd8, 0, 1, 0, 0, 2, 1, 1, 3'd3, "R9 multi 3 over 4,7");
        drive(3'd3, 32'h1FFF_FFF8, 8'd16,0, 1, 0, 0, 2, 1, 1, 3'd4, "R9 string 4 over 7");
        repeat (2) @(negedge clk);

        // R10: reset clears a standing fault on the next edge
        drive(3'd6, 32'h0000_6001, 8'd4, 0, 0, 0, 0, 2, 0, 1, 3'd6, "R10 fault before reset");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 check("R10 mid-run reset", 1'b0, 3'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 check("R10 resumes after reset", 1'b1, 3'd6);
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule